// File: doc/BRIEF.md
# GPIO Port Pin-Control Register Block

This block holds the control state of one 32-pin general-purpose I/O port behind a word-wide register bus. Every pin owns a 4-bit mode code. The code decides whether the pad is driven, left floating for input, handed to an interrupt detector, switched off, or offered to an external alternate-function multiplexer that receives the raw code.

A data word gives output values for pins in output mode. A read of the same word returns the pad levels after a two-stage synchronizer, and the synchronized levels are also exported for the interrupt detector. Drive-strength and pull-selection words are only stored and exported as plain control vectors for the pad ring.

Software changes one pin by reading its configuration word, replacing the nibble and writing the word back. The block keeps every configuration word independent, so a write disturbs no other word.

Top module: `pinctl_port`

## Requirements
- R1: After reset every pin mode reads 15 (configuration words read 0xFFFFFFFF). The data, drive and pull words read 0, the read data port is 0 and no output enable is asserted.
- R2: The mode of pin n is bits (n mod 8)*4+3 .. (n mod 8)*4 of the configuration word at byte offset 4*(n/8), offsets 0x00 to 0x0C. It appears on `pin_mode[4n+3:4n]`.
- R3: A write to one configuration word changes only the eight pins it covers. The written value reads back unchanged and the other three configuration words keep their contents.
- R4: `pad_oe[n]` is 1 exactly when pin n has mode 1. `pad_out[n]` equals bit n of the data word when `pad_oe[n]` is 1, and is 0 otherwise.
- R5: `irq_sel[n]` is 1 exactly when pin n has mode 14. Modes 0, 14 and 15 never assert `pad_oe`.
- R6: Mode codes 2 to 13 select an alternate function. They assert neither `pad_oe` nor `irq_sel`, and the code is passed unchanged on `pin_mode`.
- R7: Reads of the data word at offset 0x10 return `pad_in` through two flip-flop stages. A level applied before clock edge A is missed by reads sampled at edges A and A+1, and is returned by a read sampled at edge A+2.
- R8: A write to offset 0x10 sets the output values. A later read of 0x10 returns the pad levels, not the written value.
- R9: The four drive words at 0x14, 0x18, 0x1C and 0x20 and the two pull words at 0x24 and 0x28 read back as written. Word k of each group appears on bits 32k+31:32k of `drive_ctl` and `pull_ctl` respectively.
- R10: `bus_rdata` is loaded at the clock edge that samples `bus_rd_en` high, and holds that value while `bus_rd_en` stays low.
- R11: Offsets that are not a multiple of 4, or that are 0x2C or above, are unmapped. Writes to them change no register and no output, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_rd_en | input | 1 | Read strobe; data is returned after the next edge |
| bus_addr | input | 8 | Byte offset within the port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Output value per pin, gated by output enable |
| pad_oe | output | 32 | Output enable per pin |
| pin_mode | output | 128 | 4-bit mode code per pin, for the alternate-function mux |
| irq_sel | output | 32 | Pin routed to the interrupt detector |
| pin_level | output | 32 | Synchronized pad levels |
| drive_ctl | output | 128 | Drive-strength control words |
| pull_ctl | output | 64 | Pull-selection control words |

## Verification
Mode decoding is tried with three word patterns. The first puts ascending codes 0 to 7 into one word, which shows whether nibbles are packed and placed correctly. The second fills a word with output codes, which separates the output-enable gating from the data value. The third mixes interrupt, disabled, input and alternate codes, which shows whether each class is decoded apart from the others. Pad patterns are applied against a fixed read strobe so that a synchronizer one stage short or one stage long gives a different result. Writes to misaligned offsets and to offsets just above the map, followed by a full read-back, catch address aliasing.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

  localparam int unsigned MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_INPUT  = 4'd0;
  localparam logic [MODE_W-1:0] MODE_OUTPUT = 4'd1;
  localparam logic [MODE_W-1:0] MODE_IRQ    = 4'd14;
  localparam logic [MODE_W-1:0] MODE_OFF    = 4'd15;

  typedef enum logic [1:0] {
    PK_FLOAT = 2'd0,  // input, disabled or alternate: pad not driven here
    PK_DRIVE = 2'd1,  // output mode: pad driven from data word
    PK_IRQ   = 2'd2   // routed to interrupt detector
  } pin_kind_e;

  function automatic pin_kind_e classify_mode(input logic [MODE_W-1:0] code);
    pin_kind_e kind;
    unique case (code)
      MODE_OUTPUT: kind = PK_DRIVE;
      MODE_IRQ:    kind = PK_IRQ;
      default:     kind = PK_FLOAT;
    endcase
    return kind;
  endfunction

endpackage

// File: rtl/pinctl_rst_sync.sv
module pinctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] shift_q;
  logic [1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[1];

endmodule

// File: rtl/pinctl_in_sync.sv
module pinctl_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = din;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pinctl_pin_decode.sv
module pinctl_pin_decode
  import pinctl_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic [NUM_PINS*MODE_W-1:0] mode_flat,
  input  logic [NUM_PINS-1:0]        out_val,
  output logic [NUM_PINS-1:0]        oe,
  output logic [NUM_PINS-1:0]        drive_val,
  output logic [NUM_PINS-1:0]        irq_route
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_kind_e kind;

    always_comb begin
      kind         = classify_mode(mode_flat[p*MODE_W +: MODE_W]);
      oe[p]        = (kind == PK_DRIVE);
      irq_route[p] = (kind == PK_IRQ);
      drive_val[p] = (kind == PK_DRIVE) ? out_val[p] : 1'b0;
    end
  end

endmodule

// File: rtl/pinctl_regs.sv
module pinctl_regs
  import pinctl_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DRV_W    = 4,
  parameter int unsigned PULL_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  input  logic [NUM_PINS-1:0]        level,
  output logic [NUM_PINS*MODE_W-1:0] mode_flat,
  output logic [NUM_PINS-1:0]        out_val,
  output logic [NUM_PINS*DRV_W-1:0]  drv_flat,
  output logic [NUM_PINS*PULL_W-1:0] pull_flat
);

  localparam int unsigned CFG_WORDS  = NUM_PINS * MODE_W / DATA_W;
  localparam int unsigned DRV_WORDS  = NUM_PINS * DRV_W / DATA_W;
  localparam int unsigned PULL_WORDS = NUM_PINS * PULL_W / DATA_W;
  localparam int unsigned DATA_IDX   = CFG_WORDS;
  localparam int unsigned DRV_BASE   = DATA_IDX + 1;
  localparam int unsigned PULL_BASE  = DRV_BASE + DRV_WORDS;
  localparam int unsigned TOTAL      = PULL_BASE + PULL_WORDS;
  localparam int unsigned BYTE_SH    = $clog2(DATA_W / 8);
  localparam int unsigned IDX_W      = ADDR_W - BYTE_SH;

  logic [IDX_W-1:0]  word_idx;
  logic              aligned;
  logic              mapped;
  logic [DATA_W-1:0] word_q [TOTAL];
  logic [DATA_W-1:0] word_d [TOTAL];
  logic [TOTAL-1:0]  word_we;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  // Address decode
  always_comb begin
    word_idx = addr[ADDR_W-1:BYTE_SH];
    aligned  = (addr[BYTE_SH-1:0] == '0);
    mapped   = aligned && (word_idx < IDX_W'(TOTAL));
  end

  // Storage words: configuration, data, drive, pull
  for (genvar w = 0; w < TOTAL; w++) begin : g_word
    localparam logic [DATA_W-1:0] RST_VAL = (w < CFG_WORDS) ? '1 : '0;

    always_comb begin
      word_we[w] = wr_en && mapped && (word_idx == IDX_W'(w));
      word_d[w]  = word_we[w] ? wdata : word_q[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= RST_VAL;
      end else begin
        word_q[w] <= word_d[w];
      end
    end
  end

  // Read mux: the data word reads back pad levels
  always_comb begin
    rd_word = '0;
    for (int w = 0; w < int'(TOTAL); w++) begin
      if (mapped && (word_idx == IDX_W'(w))) begin
        if (w == int'(DATA_IDX)) begin
          rd_word = DATA_W'(level);
        end else begin
          rd_word = word_q[w];
        end
      end
    end
    rdata_d = rd_en ? rd_word : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

  // Flatten exported fields
  for (genvar w = 0; w < CFG_WORDS; w++) begin : g_cfg_out
    assign mode_flat[w*DATA_W +: DATA_W] = word_q[w];
  end
  for (genvar w = 0; w < DRV_WORDS; w++) begin : g_drv_out
    assign drv_flat[w*DATA_W +: DATA_W] = word_q[DRV_BASE + w];
  end
  for (genvar w = 0; w < PULL_WORDS; w++) begin : g_pull_out
    assign pull_flat[w*DATA_W +: DATA_W] = word_q[PULL_BASE + w];
  end
  assign out_val = word_q[DATA_IDX][NUM_PINS-1:0];

endmodule

// File: rtl/pinctl_port.sv
module pinctl_port
  import pinctl_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DRV_W    = 4,
  parameter int unsigned PULL_W   = 2,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr_en,
  input  logic                       bus_rd_en,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]        pad_in,
  output logic [NUM_PINS-1:0]        pad_out,
  output logic [NUM_PINS-1:0]        pad_oe,
  output logic [NUM_PINS*MODE_W-1:0] pin_mode,
  output logic [NUM_PINS-1:0]        irq_sel,
  output logic [NUM_PINS-1:0]        pin_level,
  output logic [NUM_PINS*DRV_W-1:0]  drive_ctl,
  output logic [NUM_PINS*PULL_W-1:0] pull_ctl
);

  logic                       rst_int_n;
  logic [NUM_PINS-1:0]        level_s;
  logic [NUM_PINS*MODE_W-1:0] mode_flat;
  logic [NUM_PINS-1:0]        out_val;

  pinctl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pinctl_in_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STG)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (pad_in),
    .dout  (level_s)
  );

  pinctl_regs #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .DRV_W    (DRV_W),
    .PULL_W   (PULL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (bus_wr_en),
    .rd_en     (bus_rd_en),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .level     (level_s),
    .mode_flat (mode_flat),
    .out_val   (out_val),
    .drv_flat  (drive_ctl),
    .pull_flat (pull_ctl)
  );

  pinctl_pin_decode #(
    .NUM_PINS (NUM_PINS)
  ) u_dec (
    .mode_flat (mode_flat),
    .out_val   (out_val),
    .oe        (pad_oe),
    .drive_val (pad_out),
    .irq_route (irq_sel)
  );

  assign pin_mode  = mode_flat;
  assign pin_level = level_s;

endmodule

// File: rtl/pinctl_port_chk.sv
module pinctl_port_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DRV_W    = 4,
  parameter int unsigned PULL_W   = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr_en,
  input logic                  bus_rd_en,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS*4-1:0] pin_mode,
  input logic [NUM_PINS-1:0]   irq_sel
);

  localparam int unsigned TOTAL = NUM_PINS * (4 + 1 + DRV_W + PULL_W) / DATA_W;
  localparam int unsigned BYTE_SH = $clog2(DATA_W / 8);
  localparam int unsigned DATA_OFS = (NUM_PINS * 4 / DATA_W) * (DATA_W / 8);

  logic unmapped;
  always_comb begin
    unmapped = (bus_addr[BYTE_SH-1:0] != '0) ||
               (bus_addr[ADDR_W-1:BYTE_SH] >= (ADDR_W-BYTE_SH)'(TOTAL));
  end

  // R4: enable only for output code
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    a_r4_oe_matches_mode: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[p] == (pin_mode[p*4 +: 4] == 4'd1));
    a_r5_irq_matches_mode: assert property (@(posedge clk) disable iff (!rst_n)
      irq_sel[p] == (pin_mode[p*4 +: 4] == 4'd14));
  end

  // R4: undriven pins carry 0
  a_r4_out_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R11: unmapped read returns zero
  a_r11_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && unmapped) |=> (bus_rdata == '0));

  // R3: data-word writes leave every mode untouched
  a_r3_data_write_keeps_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == ADDR_W'(DATA_OFS)) |=> $stable(pin_mode));

  // R10: read data holds without a strobe
  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_en) |=> $stable(bus_rdata));

endmodule

bind pinctl_port pinctl_port_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .DRV_W    (DRV_W),
  .PULL_W   (PULL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_rd_en (bus_rd_en),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pin_mode  (pin_mode),
  .irq_sel   (irq_sel)
);

// File: tb/test_pinctl_port.sv
module test_pinctl_port;

  logic         clk;
  logic         rst_n;
  logic         bus_wr_en;
  logic         bus_rd_en;
  logic [7:0]   bus_addr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [31:0]  pad_in;
  logic [31:0]  pad_out;
  logic [31:0]  pad_oe;
  logic [127:0] pin_mode;
  logic [31:0]  irq_sel;
  logic [31:0]  pin_level;
  logic [127:0] drive_ctl;
  logic [63:0]  pull_ctl;

  int n_cmp = 0;
  int n_bad = 0;

  // Model of stored words: 0-3 config, 4 data, 5-8 drive, 9-10 pull
  logic [31:0] m_word [11];

  pinctl_port i_pinctl_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pin_mode  (pin_mode),
    .irq_sel   (irq_sel),
    .pin_level (pin_level),
    .drive_ctl (drive_ctl),
    .pull_ctl  (pull_ctl)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    if (a[1:0] == 2'b00 && a < 8'h2C) m_word[a[7:2]] = d;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr  = a;
    bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    v = bus_rdata;
  endtask

  function automatic logic [3:0] m_mode(input int p);
    return m_word[p / 8][(p % 8) * 4 +: 4];
  endfunction

  function automatic logic [31:0] exp_oe();
    logic [31:0] r;
    for (int p = 0; p < 32; p++) r[p] = (m_mode(p) == 4'd1);
    return r;
  endfunction

  function automatic logic [31:0] exp_irq();
    logic [31:0] r;
    for (int p = 0; p < 32; p++) r[p] = (m_mode(p) == 4'd14);
    return r;
  endfunction

  task automatic check_pins(input string tag);
    check({tag, " oe"},  pad_oe,  exp_oe());
    check({tag, " out"}, pad_out, m_word[4] & exp_oe());
    check({tag, " irq"}, irq_sel, exp_irq());
    check({tag, " mode"}, pin_mode, {m_word[3], m_word[2], m_word[1], m_word[0]});
  endtask

  task automatic check_all_words(input string tag);
    logic [31:0] v;
    for (int w = 0; w < 11; w++) begin
      rd(8'(w * 4), v);
      if (w == 4) check({tag, " data"}, v, pad_in);
      else        check({tag, " word"}, v, m_word[w]);
    end
  endtask

  task automatic t_reset();
    check("R1 rdata", bus_rdata, 32'h0);
    for (int w = 0; w < 11; w++) m_word[w] = (w < 4) ? 32'hFFFF_FFFF : 32'h0;
    check_pins("R1");
    check("R1 drive", drive_ctl, 128'h0);
    check("R1 pull", pull_ctl, 64'h0);
    check_all_words("R1");
  endtask

  task automatic t_cfg_place();
    logic [31:0] v;
    wr(8'h04, 32'h7654_3210);
    check("R2 pin12 nibble", pin_mode[12*4 +: 4], 4'd4);
    check("R2 pin15 nibble", pin_mode[15*4 +: 4], 4'd7);
    check("R2 pin9 oe", pad_oe[9], 1'b1);
    rd(8'h04, v);
    check("R3 readback", v, 32'h7654_3210);
    rd(8'h00, v);
    check("R3 word0 kept", v, 32'hFFFF_FFFF);
    rd(8'h0C, v);
    check("R3 word3 kept", v, 32'hFFFF_FFFF);
    check_pins("R2");
  endtask

  task automatic t_out_drive();
    logic [31:0] v;
    wr(8'h00, 32'h1111_1111);
    wr(8'h10, 32'hA5A5_02FF);
    check_pins("R4");
    check("R4 out value", pad_out, 32'h0000_02FF);
    pad_in = 32'h0F0F_0F0F;
    repeat (3) @(negedge clk);
    rd(8'h10, v);
    check("R8 data reads pads", v, 32'h0F0F_0F0F);
  endtask

  task automatic t_irq_alt();
    wr(8'h08, 32'hEF2D_01E7);
    check_pins("R5");
    check("R5 irq bits", irq_sel, 32'h0082_0000);
    check("R6 alt code pin20", pin_mode[20*4 +: 4], 4'd13);
    check("R6 alt no oe", pad_oe[21:20], 2'b00);
    check("R6 alt no irq", irq_sel[16], 1'b0);
  endtask

  task automatic t_sync();
    pad_in = 32'h0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    pad_in    = 32'h1234_5678;
    bus_addr  = 8'h10;
    bus_rd_en = 1'b1;
    @(negedge clk);
    check("R7 edge A old", bus_rdata, 32'h0);
    @(negedge clk);
    check("R7 edge A+1 old", bus_rdata, 32'h0);
    @(negedge clk);
    check("R7 edge A+2 new", bus_rdata, 32'h1234_5678);
    bus_rd_en = 1'b0;
    pad_in    = 32'hDEAD_BEEF;
    repeat (4) @(negedge clk);
    check("R10 rdata held", bus_rdata, 32'h1234_5678);
  endtask

  task automatic t_drv_pull();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) wr(8'(8'h14 + k * 4), 32'h1000_0001 * (k + 3));
    wr(8'h24, 32'hCAFE_0011);
    wr(8'h28, 32'h0BAD_F00D);
    rd(8'h1C, v);
    check("R9 drive2 readback", v, 32'h1000_0001 * 5);
    rd(8'h28, v);
    check("R9 pull1 readback", v, 32'h0BAD_F00D);
    check("R9 drive export", drive_ctl, {m_word[8], m_word[7], m_word[6], m_word[5]});
    check("R9 pull export", pull_ctl, {m_word[10], m_word[9]});
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h30, 32'h0000_0000);
    wr(8'h11, 32'h0000_0000);
    wr(8'h06, 32'h0000_0000);
    wr(8'hFC, 32'h5555_5555);
    check_pins("R11");
    check("R11 drive kept", drive_ctl, {m_word[8], m_word[7], m_word[6], m_word[5]});
    check_all_words("R11");
    rd(8'h24, v);
    rd(8'h2C, v);
    check("R11 read 0x2C", v, 32'h0);
    rd(8'h24, v);
    rd(8'h15, v);
    check("R11 read misaligned", v, 32'h0);
  endtask

  initial begin
    rst_n     = 1'b0;
    bus_wr_en = 1'b0;
    bus_rd_en = 1'b0;
    bus_addr  = 8'h0;
    bus_wdata = 32'h0;
    pad_in    = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg_place();
    t_out_drive();
    t_irq_alt();
    t_sync();
    t_drv_pull();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule